// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Fault Latch

This block turns two direction inputs and a pair of enable controls (an active-high enable and an active-high disable) into gate commands for the two half-bridge legs of a motor bridge. Each leg has a high-side and a low-side command. With the bridge running, each leg follows its direction input: high selects the high-side device and low selects the low-side device. The block also drives an active-low status output, `sf_n`, which is low whenever the bridge is not running.

Overcurrent and overtemperature comparator levels switch the bridge off at the next clock edge and set a latched fault. The fault clears only on an enable edge: a rising edge of the filtered enable or a falling edge of the filtered disable. A hold timer then keeps the bridge off for a fixed reactivation interval after any trip. Undervoltage switches the bridge off without latching, and the bridge resumes by itself when the supply recovers.

Whenever the bridge is off, a leg whose output-below-ground sense is set turns on its low-side device so that the freewheel current of an inductive load flows through the transistor and not through the diode. No leg ever commands both devices at once, and a parameterised dead time separates the turn-off of one device from the turn-on of the other.

Top module: `hbridge_ctrl`

## Requirements
- R1: While running, each leg follows its direction input in steady state. A high input gives high-side on and low-side off. A low input gives low-side on and high-side off. Leg A follows `in_a` and leg B follows `in_b`, and `sf_n` is 1.
- R2: While reset is asserted, all gate commands and `sf_n` are 0. Any filtered state with the disable high or the enable low keeps all high-side commands at 0 and `sf_n` at 0. With both below-ground senses at 0, all low-side commands are also 0.
- R3: A new level on `en_i` or `dis_i` takes effect only after `FILT_CYC` consecutive rising-edge samples at that level. `sf_n` reflects the new level at the (`FILT_CYC`+1)-th rising edge. A pulse lasting `FILT_CYC`-1 samples has no effect.
- R4: When `oc_i` or `ot_i` is sampled high, all high-side commands and `sf_n` are 0 after that edge. The fault is latched, so the bridge stays off after the fault input returns low.
- R5: The latched fault clears only on a rising edge of the filtered enable or a falling edge of the filtered disable. An edge that occurs while a fault input is still high does not clear it.
- R6: After a fault is sampled, `sf_n` stays 0 for at least `HOLD_CYC` edges, even if a clearing edge comes earlier. The bridge resumes within a few cycles after the hold interval ends.
- R7: `uv_i` sampled high forces all high-side commands and `sf_n` to 0 after that edge, without latching. `sf_n` returns to 1 at the first edge at which `uv_i` is sampled low, provided the bridge is enabled and no fault or hold is active.
- R8: While the bridge is off, a leg's low-side command turns on when its below-ground sense (`neg_a`/`neg_b`) is 1 and goes off at the first edge at which that sense is sampled 0. The high-side command of that leg stays 0.
- R9: A leg never has both commands at 1. Between one device turning off and the other device of the same leg turning on, both commands are 0 for at least `DEAD_CYC` cycles.
- R10: While the bridge is running, the below-ground senses have no effect on the gate commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Direction input for leg A |
| in_b | input | 1 | Direction input for leg B |
| en_i | input | 1 | Enable, active high, filtered |
| dis_i | input | 1 | Disable, active high, filtered |
| oc_i | input | 1 | Overcurrent comparator level |
| ot_i | input | 1 | Overtemperature comparator level |
| uv_i | input | 1 | Undervoltage comparator level |
| neg_a | input | 1 | Leg A output is below ground |
| neg_b | input | 1 | Leg B output is below ground |
| hs_a | output | 1 | Leg A high-side gate command |
| ls_a | output | 1 | Leg A low-side gate command |
| hs_b | output | 1 | Leg B high-side gate command |
| ls_b | output | 1 | Leg B low-side gate command |
| sf_n | output | 1 | Status, low while the bridge is off |

## Verification
Some properties are checked on every cycle. These are: leg exclusivity, the off cycle before any turn-on, the one-edge shutdown on a fault or undervoltage sample, no high-side drive while the status is low, low-side freewheel only after a below-ground sample, and that a fault clears only after a clearing edge. Other behaviour is shown only by the bench scenarios. These are the exact enable-filter latency and glitch rejection, and the hold interval outlasting an early clear. They also include a fault input that stays high blocking a clear, automatic undervoltage recovery, and the full truth-table sweep over enable, disable and both directions. The dead-time length is measured by a bench monitor on every transition.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    CMD_OFF  = 2'd0,
    CMD_HIGH = 2'd1,
    CMD_LOW  = 2'd2
  } leg_cmd_e;

  // Per-leg command: direction while running, freewheel low side when off.
  function automatic leg_cmd_e pick_cmd(input logic run, input logic dir,
                                        input logic neg);
    leg_cmd_e c;
    if (run)      c = dir ? CMD_HIGH : CMD_LOW;
    else if (neg) c = CMD_LOW;
    else          c = CMD_OFF;
    return c;
  endfunction

endpackage

// File: rtl/hb_filter.sv
module hb_filter #(
  parameter int unsigned STABLE_CYC = 150,
  parameter logic        RST_VAL    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (raw_i != lvl_q) begin
      if (cnt_q == CW'(STABLE_CYC - 1)) lvl_d = raw_i;
      else                              cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign clean_o = lvl_q;

endmodule

// File: rtl/hb_fault.sv
module hb_fault #(
  parameter int unsigned HOLD_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic en_f,
  input  logic dis_f,
  output logic fault_o,
  output logic hold_o
);
  localparam int unsigned HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);

  logic          fault_q, fault_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          en_prev_q, dis_prev_q;
  logic          clr;

  assign clr = (en_f & ~en_prev_q) | (dis_prev_q & ~dis_f);

  always_comb begin
    fault_d = trip_i | (fault_q & ~clr);
    if (trip_i)            hold_d = HW'(HOLD_CYC);
    else if (hold_q != '0) hold_d = hold_q - 1'b1;
    else                   hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q    <= 1'b0;
      hold_q     <= '0;
      en_prev_q  <= 1'b0;
      dis_prev_q <= 1'b1;
    end else begin
      fault_q    <= fault_d;
      hold_q     <= hold_d;
      en_prev_q  <= en_f;
      dis_prev_q <= dis_f;
    end
  end

  assign fault_o = fault_q;
  assign hold_o  = (hold_q != '0);

  p_clear_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(clr));

endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_e cmd_i,
  output logic     hs_o,
  output logic     ls_o
);
  localparam int unsigned DW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);

  logic          hs_q, hs_d, ls_q, ls_d;
  logic [DW-1:0] gap_q, gap_d;
  logic          want_hs, want_ls;

  assign want_hs = (cmd_i == CMD_HIGH);
  assign want_ls = (cmd_i == CMD_LOW);

  always_comb begin
    hs_d  = hs_q & want_hs;
    ls_d  = ls_q & want_ls;
    gap_d = gap_q;
    if (hs_q | ls_q) begin
      gap_d = '0;
    end else if (gap_q != DW'(DEAD_CYC)) begin
      gap_d = gap_q + 1'b1;
    end else begin
      hs_d = want_hs;
      ls_d = want_ls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      gap_q <= DW'(DEAD_CYC);
    end else begin
      hs_q  <= hs_d;
      ls_q  <= ls_d;
      gap_q <= gap_d;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));
  p_hs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> $past(!ls_q));
  p_ls_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> $past(!hs_q));

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned FILT_CYC = 150,
  parameter int unsigned HOLD_CYC = 50000,
  parameter int unsigned DEAD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  input  logic en_i,
  input  logic dis_i,
  input  logic oc_i,
  input  logic ot_i,
  input  logic uv_i,
  input  logic neg_a,
  input  logic neg_b,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic sf_n
);
  localparam int unsigned NLEG = 2;

  logic en_f, dis_f, fault_q, hold_busy, trip;
  logic run_q, run_d;
  logic [NLEG-1:0] dir_v, neg_v, hs_v, ls_v;

  hb_filter #(.STABLE_CYC(FILT_CYC), .RST_VAL(1'b0)) u_en_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(en_i), .clean_o(en_f));
  hb_filter #(.STABLE_CYC(FILT_CYC), .RST_VAL(1'b1)) u_dis_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(dis_i), .clean_o(dis_f));

  assign trip = oc_i | ot_i;

  hb_fault #(.HOLD_CYC(HOLD_CYC)) u_fault (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .en_f(en_f), .dis_f(dis_f),
    .fault_o(fault_q), .hold_o(hold_busy));

  // Faults and undervoltage override the enable-driven state.
  assign run_d = en_f & ~dis_f & ~trip & ~uv_i & ~fault_q & ~hold_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign dir_v = {in_b, in_a};
  assign neg_v = {neg_b, neg_a};

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    leg_cmd_e cmd;
    assign cmd = pick_cmd(run_d, dir_v[g], neg_v[g]);
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .hs_o(hs_v[g]), .ls_o(ls_v[g]));
  end

  assign hs_a = hs_v[0];
  assign ls_a = ls_v[0];
  assign hs_b = hs_v[1];
  assign ls_b = ls_v[1];
  assign sf_n = run_q;

  p_trip_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_i || ot_i) |=> (!sf_n && !hs_a && !hs_b));
  p_uv_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (!sf_n && !hs_a && !hs_b));
  p_off_no_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_n |-> (!hs_a && !hs_b));
  p_fw_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sf_n && ls_a) |-> $past(neg_a));
  p_fw_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sf_n && ls_b) |-> $past(neg_b));

endmodule

// File: tb/hbridge_ctrl_bench.sv
module hbridge_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int HOLD = 40;
  localparam int DEAD = 3;
  localparam int SETTLE = 2 * FILT + DEAD + 4;

  logic clk, rst_n;
  logic in_a, in_b, en_i, dis_i, oc_i, ot_i, uv_i, neg_a, neg_b;
  logic hs_a, ls_a, hs_b, ls_b, sf_n;
  int total, bad;

  hbridge_ctrl #(.FILT_CYC(FILT), .HOLD_CYC(HOLD), .DEAD_CYC(DEAD)) u_hbridge_ctrl (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .en_i(en_i),
    .dis_i(dis_i), .oc_i(oc_i), .ot_i(ot_i), .uv_i(uv_i), .neg_a(neg_a),
    .neg_b(neg_b), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
    .sf_n(sf_n));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Observed vector {sf_n, hs_a, ls_a, hs_b, ls_b}
  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {sf_n, hs_a, ls_a, hs_b, ls_b};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] run_vec(input logic a, input logic b);
    return {1'b1, a, ~a, b, ~b};
  endfunction

  // R9 monitor: exclusivity and dead-time length per leg
  int   idle_n [2];
  logic last_hs [2];
  logic seen [2];
  always @(negedge clk) begin
    logic [1:0] hv, lv;
    hv = {hs_b, hs_a};
    lv = {ls_b, ls_a};
    if (rst_n) begin
      for (int g = 0; g < 2; g++) begin
        if (hv[g] && lv[g]) begin
          total++; bad++;
          $display("FAIL R9: leg %0d actual=both_on expected=exclusive", g);
        end
        if ((hv[g] || lv[g]) && seen[g] && (hv[g] != last_hs[g]) && idle_n[g] >= 0) begin
          if (idle_n[g] > 0 || (hv[g] != last_hs[g])) begin
            total++;
            if (idle_n[g] < DEAD) begin
              bad++;
              $display("FAIL R9: leg %0d gap actual=%0d expected>=%0d", g, idle_n[g], DEAD);
            end
          end
        end
        if (hv[g] || lv[g]) begin
          idle_n[g]  = 0;
          last_hs[g] = hv[g];
          seen[g]    = 1'b1;
        end else begin
          idle_n[g]++;
        end
      end
    end else begin
      for (int g = 0; g < 2; g++) begin
        idle_n[g] = 0; seen[g] = 1'b0; last_hs[g] = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; in_a = 1'b0; in_b = 1'b0; en_i = 1'b1; dis_i = 1'b0;
    oc_i = 1'b0; ot_i = 1'b0; uv_i = 1'b0; neg_a = 1'b0; neg_b = 1'b0;
    step(3);
    chk("R2 reset", 5'b0);
    rst_n = 1'b1;
    step(SETTLE);
    chk("R1 after reset", run_vec(1'b0, 1'b0));

    // R1/R2 sweep over enable, disable and both directions
    for (int e = 0; e < 2; e++)
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++) begin
            en_i = e[0]; dis_i = d[0]; in_a = a[0]; in_b = b[0];
            step(SETTLE);
            if (e == 1 && d == 0) chk("R1 truth table", run_vec(a[0], b[0]));
            else                  chk("R2 disabled", 5'b0);
          end

    // R3 filter latency and glitch rejection
    en_i = 1'b1; dis_i = 1'b0; in_a = 1'b1; in_b = 1'b0;
    step(SETTLE);
    dis_i = 1'b1;
    step(FILT - 1);
    dis_i = 1'b0;
    step(FILT + 2);
    chk("R3 short pulse ignored", run_vec(1'b1, 1'b0));
    dis_i = 1'b1;
    step(FILT);
    total++;
    if (sf_n !== 1'b1) begin bad++; $display("FAIL R3: early sf_n actual=%b expected=1", sf_n); end
    step(1);
    total++;
    if (sf_n !== 1'b0) begin bad++; $display("FAIL R3: late sf_n actual=%b expected=0", sf_n); end
    dis_i = 1'b0;
    step(SETTLE);
    chk("R3 recovered", run_vec(1'b1, 1'b0));

    // R4 trip and latch
    oc_i = 1'b1;
    step(1);
    chk("R4 trip off", 5'b0);
    oc_i = 1'b0;
    step(HOLD + 10);
    chk("R4 latched", 5'b0);
    // R5 clear blocked by active fault input
    oc_i = 1'b1;
    en_i = 1'b0; step(FILT + 2);
    en_i = 1'b1; step(SETTLE);
    chk("R5 active fault blocks clear", 5'b0);
    oc_i = 1'b0;
    step(HOLD + 5);
    chk("R5 no clear without edge", 5'b0);
    en_i = 1'b0; step(FILT + 2);
    en_i = 1'b1; step(SETTLE);
    chk("R5 enable rise clears", run_vec(1'b1, 1'b0));

    // R6 hold interval outlasts an early clear (disable falling edge)
    ot_i = 1'b1;
    step(1);
    chk("R4 ot trip", 5'b0);
    ot_i = 1'b0;
    dis_i = 1'b1; step(FILT + 2);
    dis_i = 1'b0; step(FILT + 2);
    step(HOLD - 1 - (2 * FILT + 4));
    total++;
    if (sf_n !== 1'b0) begin bad++; $display("FAIL R6: hold sf_n actual=%b expected=0", sf_n); end
    step(4);
    total++;
    if (sf_n !== 1'b1) begin bad++; $display("FAIL R6: resume sf_n actual=%b expected=1", sf_n); end
    step(DEAD + 3);
    chk("R6 resumed", run_vec(1'b1, 1'b0));

    // R7 undervoltage auto recovery
    uv_i = 1'b1;
    step(1);
    chk("R7 uv off", 5'b0);
    uv_i = 1'b0;
    step(1);
    total++;
    if (sf_n !== 1'b1) begin bad++; $display("FAIL R7: recovery sf_n actual=%b expected=1", sf_n); end
    step(DEAD + 3);
    chk("R7 uv recovered", run_vec(1'b1, 1'b0));

    // R10 sense ignored while running, R8 freewheel when off
    neg_a = 1'b1; neg_b = 1'b1;
    step(DEAD + 3);
    chk("R10 sense ignored", run_vec(1'b1, 1'b0));
    neg_b = 1'b0;
    en_i = 1'b0;
    step(FILT + DEAD + 4);
    chk("R8 freewheel leg a", 5'b00100);
    neg_a = 1'b0;
    step(1);
    chk("R8 freewheel ends", 5'b0);
    neg_b = 1'b1;
    step(DEAD + 3);
    chk("R8 freewheel leg b", 5'b00001);
    neg_b = 1'b0;
    en_i = 1'b1;
    step(SETTLE);
    chk("R1 final run", run_vec(1'b1, 1'b0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule